// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Generator

This block generates the four gate-logic signals of a phase-shifted full bridge. A half-period counter runs the lead leg as a square wave at the switching rate. At the start of each half period a digital ramp restarts from zero. The ramp is compared with a control word, and each crossing toggles a flip-flop that drives the lag leg. The overlap between the two legs therefore follows the control word, and energy is delivered through alternating diagonal pairs.

The comparison source is selectable. It can be a fixed-slope ramp (voltage mode), a ramp whose per-clock increment is an input-voltage code (feed-forward), or a sampled current code that stands in for the ramp (peak current mode). A programmable dead time holds both switches of a leg off around every transition of that leg. All settings take effect at period boundaries, so the settings always match within a period. Compensation, sensing and gate drive are handled outside the block.

Top module: `psfb_pwm_gen`

## Requirements
- R1: While rst_ni is low all four outputs are low. On any rising edge that samples en_i low, all four outputs are low after that edge.
- R2: One switching period lasts period_i clocks, and period_i must be even and at least 4. Half a period lasts period_i/2 clocks. With dead_i = 0, lead_hi_o is high for the first half of every period and lead_lo_o is high for the second half.
- R3: After the first rising edge that samples en_i high, lead_hi_o and lag_lo_o are high and lead_lo_o and lag_hi_o are low.
- R4: In voltage mode (mode_i = 0 or 3) the ramp is 0 in the first clock of each half period and rises by 1 each clock. Take the first clock in which the ramp exceeds cmp_i. The lag leg outputs swap sides on the second rising edge after the start of that clock.
- R5: In feed-forward mode (mode_i = 1) the ramp rises by vin_i each clock and saturates at 2^16-1. The trip rule and timing of R4 apply.
- R6: In peak current mode (mode_i = 2) the value of isense_i during each clock replaces the ramp in the R4 comparison.
- R7: The lag leg swaps at most once per half period, even if the comparison stays true or falls and rises again before the next half period begins.
- R8: lead_hi_o and lead_lo_o are never high together, and lag_hi_o and lag_lo_o are never high together.
- R9: When the internal state of a leg changes, both outputs of that leg stay low for dead_i clocks before the new side turns on. With dead_i = 0 the outputs switch sides on the same edge.
- R10: period_i, cmp_i, vin_i, mode_i and dead_i are captured on the edge that starts a switching period, and on every edge while en_i is low. A change made within a period takes effect from the next period.
- R11: cmp_i = 0 trips in the first clock of every half period. In voltage mode, cmp_i at or above period_i/2 - 1 (the ramp maximum) produces no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the bridge off and idle |
| period_i | input | 16 | Switching period in clocks (even, >= 4) |
| cmp_i | input | 16 | Control word compared with the ramp or current sample |
| vin_i | input | 12 | Input-voltage code, used as ramp increment in feed-forward mode |
| isense_i | input | 16 | Sampled current code for peak current mode |
| mode_i | input | 2 | 0/3 voltage mode, 1 feed-forward, 2 peak current |
| dead_i | input | 6 | Dead time in clocks applied at each leg transition |
| lead_hi_o | output | 1 | Lead leg high-side gate logic |
| lead_lo_o | output | 1 | Lead leg low-side gate logic |
| lag_hi_o | output | 1 | Lag leg high-side gate logic |
| lag_lo_o | output | 1 | Lag leg low-side gate logic |

## Verification
The ramp trip and the half-period restart can fall on the same edge. This happens when the comparison first holds in the last clock of a half period: the toggle, the re-arm of the trip, the ramp reset and the lead leg transition then all happen on one edge. The bench provokes this with a compare word one below the ramp maximum. It expects the toggle to count for the half that is ending and the next half to trip again in its own last clock, so both legs enter their dead time on the same cycle. A zero compare word places the trip in the restart clock itself and is judged the same way, against a bench model that works out trip positions and dead-time gaps from the requirements.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  typedef enum logic [1:0] {
    SRC_VOLT = 2'd0,
    SRC_VFF  = 2'd1,
    SRC_PEAK = 2'd2,
    SRC_ALT  = 2'd3
  } ramp_src_e;
endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RAMP_W = 16,
  parameter int VIN_W  = 12,
  parameter int DT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [RAMP_W-1:0] cmp_i,
  input  logic [VIN_W-1:0]  vin_i,
  input  ramp_src_e         mode_i,
  input  logic [DT_W-1:0]   dead_i,
  output logic              half_o,
  output logic              half_end_o,
  output logic [RAMP_W-1:0] cmp_o,
  output logic [VIN_W-1:0]  vin_o,
  output ramp_src_e         mode_o,
  output logic [DT_W-1:0]   dead_o
);
  localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, half_len_q, half_lim;
  logic             half_q, last;

  assign half_lim   = (half_len_q < MIN_HALF) ? MIN_HALF : half_len_q;
  assign last       = (cnt_q == half_lim - CNT_W'(1));
  assign half_end_o = en_i && last;
  assign half_o     = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      half_q     <= 1'b0;
      half_len_q <= MIN_HALF;
      cmp_o      <= '0;
      vin_o      <= '0;
      mode_o     <= SRC_VOLT;
      dead_o     <= '0;
    end else if (!en_i || (last && half_q)) begin
      // capture settings while idle and at each period boundary
      half_len_q <= period_i >> 1;
      cmp_o      <= cmp_i;
      vin_o      <= vin_i;
      mode_o     <= mode_i;
      dead_o     <= dead_i;
      cnt_q      <= '0;
      half_q     <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      half_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/psfb_ramp.sv
module psfb_ramp
  import psfb_pkg::*;
#(
  parameter int RAMP_W = 16,
  parameter int VIN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              half_end_i,
  input  ramp_src_e         mode_i,
  input  logic [VIN_W-1:0]  vin_i,
  input  logic [RAMP_W-1:0] isense_i,
  output logic [RAMP_W-1:0] sample_o
);
  localparam logic [RAMP_W-1:0] RAMP_MAX = '1;
  localparam logic [RAMP_W-1:0] UNIT     = RAMP_W'(1);

  logic [RAMP_W-1:0] ramp_q, step, ramp_nxt;
  logic [RAMP_W:0]   sum;

  assign step     = (mode_i == SRC_VFF) ? RAMP_W'(vin_i) : UNIT;
  assign sum      = {1'b0, ramp_q} + {1'b0, step};
  assign ramp_nxt = sum[RAMP_W] ? RAMP_MAX : sum[RAMP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ramp_q <= '0;
    else if (!en_i || half_end_i) ramp_q <= '0;
    else                          ramp_q <= ramp_nxt;
  end

  assign sample_o = (mode_i == SRC_PEAK) ? isense_i : ramp_q;
endmodule

// File: rtl/psfb_phase_tff.sv
module psfb_phase_tff #(
  parameter int RAMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              half_end_i,
  input  logic [RAMP_W-1:0] sample_i,
  input  logic [RAMP_W-1:0] cmp_i,
  output logic              lvl_o
);
  logic armed_q, tff_q, trip;

  assign trip  = armed_q && ((cmp_i == '0) || (sample_i > cmp_i));
  assign lvl_o = tff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tff_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (!en_i) begin
      tff_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (trip) tff_q <= ~tff_q;
      // restart re-arms even if this edge consumed a trip
      armed_q <= half_end_i || (armed_q && !trip);
    end
  end
endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            lvl_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic            lvl_q;
  logic [DT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else if (!run_i) begin
      lvl_q <= lvl_i;
      gap_q <= '0;
      hi_o  <= 1'b0;
      lo_o  <= 1'b0;
    end else if (lvl_i != lvl_q) begin
      lvl_q <= lvl_i;
      if (dead_i == '0) begin
        gap_q <= '0;
        hi_o  <= lvl_i;
        lo_o  <= !lvl_i;
      end else begin
        gap_q <= dead_i;
        hi_o  <= 1'b0;
        lo_o  <= 1'b0;
      end
    end else if (gap_q != '0) begin
      gap_q <= gap_q - ONE;
      if (gap_q == ONE) begin
        hi_o <= lvl_q;
        lo_o <= !lvl_q;
      end
    end else begin
      hi_o <= lvl_q;
      lo_o <= !lvl_q;
    end
  end
endmodule

// File: rtl/psfb_pwm_gen.sv
module psfb_pwm_gen
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RAMP_W = 16,
  parameter int VIN_W  = 12,
  parameter int DT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [RAMP_W-1:0] cmp_i,
  input  logic [VIN_W-1:0]  vin_i,
  input  logic [RAMP_W-1:0] isense_i,
  input  logic [1:0]        mode_i,
  input  logic [DT_W-1:0]   dead_i,
  output logic              lead_hi_o,
  output logic              lead_lo_o,
  output logic              lag_hi_o,
  output logic              lag_lo_o
);
  localparam int NUM_LEGS = 2;

  logic              half_q, half_end, tff_lvl;
  logic [RAMP_W-1:0] cmp_cfg, sample;
  logic [VIN_W-1:0]  vin_cfg;
  ramp_src_e         mode_cfg;
  logic [DT_W-1:0]   dead_cfg;
  logic [NUM_LEGS-1:0] leg_lvl, leg_hi, leg_lo;

  psfb_timebase #(
    .CNT_W(CNT_W), .RAMP_W(RAMP_W), .VIN_W(VIN_W), .DT_W(DT_W)
  ) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .period_i   (period_i),
    .cmp_i      (cmp_i),
    .vin_i      (vin_i),
    .mode_i     (ramp_src_e'(mode_i)),
    .dead_i     (dead_i),
    .half_o     (half_q),
    .half_end_o (half_end),
    .cmp_o      (cmp_cfg),
    .vin_o      (vin_cfg),
    .mode_o     (mode_cfg),
    .dead_o     (dead_cfg)
  );

  psfb_ramp #(.RAMP_W(RAMP_W), .VIN_W(VIN_W)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .half_end_i (half_end),
    .mode_i     (mode_cfg),
    .vin_i      (vin_cfg),
    .isense_i   (isense_i),
    .sample_o   (sample)
  );

  psfb_phase_tff #(.RAMP_W(RAMP_W)) u_tff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .half_end_i (half_end),
    .sample_i   (sample),
    .cmp_i      (cmp_cfg),
    .lvl_o      (tff_lvl)
  );

  // leg 0 leads (high side on in first half), leg 1 follows the toggle
  assign leg_lvl[0] = !half_q;
  assign leg_lvl[1] = tff_lvl;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_deadband #(.DT_W(DT_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (en_i),
      .lvl_i  (leg_lvl[g]),
      .dead_i (dead_cfg),
      .hi_o   (leg_hi[g]),
      .lo_o   (leg_lo[g])
    );
  end

  assign lead_hi_o = leg_hi[0];
  assign lead_lo_o = leg_lo[0];
  assign lag_hi_o  = leg_hi[1];
  assign lag_lo_o  = leg_lo[1];
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk #(
  parameter int DT_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            lead_hi_o,
  input logic            lead_lo_o,
  input logic            lag_hi_o,
  input logic            lag_lo_o,
  input logic [DT_W-1:0] dead_i,
  input logic            lag_lvl_i,
  input logic            half_end_i
);
  logic lvl_prev, wrap_d, wrap_dd, flipped_q, lag_chg;

  assign lag_chg = (lag_lvl_i != lvl_prev);

  // window of toggle detections belonging to one half period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_prev  <= 1'b0;
      wrap_d    <= 1'b0;
      wrap_dd   <= 1'b0;
      flipped_q <= 1'b0;
    end else begin
      lvl_prev <= lag_lvl_i;
      wrap_d   <= half_end_i;
      wrap_dd  <= wrap_d;
      if (!en_i)        flipped_q <= 1'b0;
      else if (wrap_dd) flipped_q <= lag_chg;
      else if (lag_chg) flipped_q <= 1'b1;
    end
  end

  // R8
  lead_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_hi_o && lead_lo_o));
  // R8
  lag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lag_hi_o && lag_lo_o));
  // R1
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(lead_hi_o || lead_lo_o || lag_hi_o || lag_lo_o));
  // R3
  start_diag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> (lead_hi_o && lag_lo_o && !lead_lo_o && !lag_hi_o));
  // R7
  one_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lag_chg && !wrap_dd) |-> !flipped_q);
  // R9
  lead_hi_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i != '0) && $rose(lead_hi_o)) |-> $past(!lead_lo_o));
  // R9
  lead_lo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i != '0) && $rose(lead_lo_o)) |-> $past(!lead_hi_o));
  // R9
  lag_hi_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i != '0) && $rose(lag_hi_o)) |-> $past(!lag_lo_o));
  // R9
  lag_lo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dead_i != '0) && $rose(lag_lo_o)) |-> $past(!lag_hi_o));
endmodule

bind psfb_pwm_gen psfb_pwm_chk #(.DT_W(DT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .lead_hi_o  (lead_hi_o),
  .lead_lo_o  (lead_lo_o),
  .lag_hi_o   (lag_hi_o),
  .lag_lo_o   (lag_lo_o),
  .dead_i     (dead_cfg),
  .lag_lvl_i  (tff_lvl),
  .half_end_i (half_end)
);

// File: tb/psfb_pwm_gen_test.sv
module psfb_pwm_gen_test;
  localparam int CNT_W = 16, RAMP_W = 16, VIN_W = 12, DT_W = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni, en;
  logic [CNT_W-1:0]  period;
  logic [RAMP_W-1:0] cmp, isense;
  logic [VIN_W-1:0]  vin;
  logic [1:0]        mode;
  logic [DT_W-1:0]   dead;
  logic lead_hi, lead_lo, lag_hi, lag_lo;

  psfb_pwm_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .period_i(period), .cmp_i(cmp),
    .vin_i(vin), .isense_i(isense), .mode_i(mode), .dead_i(dead),
    .lead_hi_o(lead_hi), .lead_lo_o(lead_lo), .lag_hi_o(lag_hi), .lag_lo_o(lag_lo)
  );

  typedef struct {
    logic [3:0] v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   n_chk = 0, n_fail = 0;
  bit   mon_on = 1'b0;

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (lead_hi lead_lo lag_hi lag_lo)", tag, got, exp);
    end
  endtask

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (mon_on && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      check({lead_hi, lead_lo, lag_hi, lag_lo}, cur.v, cur.tag);
    end
  end

  function automatic int pcm_val(input int md, input int pat, input int n, input int h);
    int k;
    k = n % h;
    if (md != 2) return 0;
    if (pat == 0) return k * 7;
    return (k >= 2 && k != 4) ? 100 : 0;
  endfunction

  // driver: build expectations from the requirements, then run the stimulus
  task automatic run_seg(input int md, input int per, input int cmp_a, input int cmp_b,
                         input int chg_at, input int vn, input int dt, input int ncyc,
                         input int pat, input string tag);
    bit r1 [0:511];
    bit r2 [0:511];
    int h, n_tot;
    bit tff, armed;
    exp_t e;
    h = per / 2;
    n_tot = ncyc * 2 * h;
    tff = 1'b0;
    armed = 1'b1;
    for (int n = 0; n <= n_tot; n++) begin
      int p, k, cyc, c;
      longint samp;
      p = n % (2 * h);
      k = p % h;
      cyc = n / (2 * h);
      c = (cyc == 0 || chg_at < 0) ? cmp_a : cmp_b;
      if (k == 0) armed = 1'b1;
      r1[n] = (p < h);
      r2[n] = tff;
      if (md == 2) samp = pcm_val(md, pat, n, h);
      else begin
        samp = longint'(k) * ((md == 1) ? vn : 1);
        if (samp > 65535) samp = 65535;
      end
      if (armed && (c == 0 || samp > c)) begin
        tff = ~tff;
        armed = 1'b0;
      end
    end
    for (int n = 1; n <= n_tot; n++) begin
      bit g1, g2;
      int lo_m;
      g1 = 1'b0;
      g2 = 1'b0;
      lo_m = (n - dt + 1 < 2) ? 2 : n - dt + 1;
      for (int m = lo_m; m <= n; m++) begin
        if (r1[m-1] != r1[m-2]) g1 = 1'b1;
        if (r2[m-1] != r2[m-2]) g2 = 1'b1;
      end
      e.v = {g1 ? 2'b00 : {r1[n-1], ~r1[n-1]}, g2 ? 2'b00 : {r2[n-1], ~r2[n-1]}};
      e.tag = tag;
      exp_q.push_back(e);
    end
    e.v = 4'b0000;
    e.tag = "R1 disable";
    exp_q.push_back(e);

    @(negedge clk);
    en = 1'b0;
    mode = md[1:0];
    period = CNT_W'(per);
    cmp = RAMP_W'(cmp_a);
    vin = VIN_W'(vn);
    dead = DT_W'(dt);
    isense = RAMP_W'(pcm_val(md, pat, 0, h));
    repeat (2) @(negedge clk);
    en = 1'b1;
    mon_on = 1'b1;
    for (int n = 1; n <= n_tot; n++) begin
      @(negedge clk);
      isense = RAMP_W'(pcm_val(md, pat, n, h));
      if (n == chg_at) cmp = RAMP_W'(cmp_b);
    end
    en = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; en = 1'b0; period = 16'd20; cmp = '0; vin = '0;
    isense = '0; mode = 2'd0; dead = '0;
    repeat (3) @(negedge clk);
    check({lead_hi, lead_lo, lag_hi, lag_lo}, 4'b0000, "R1 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check({lead_hi, lead_lo, lag_hi, lag_lo}, 4'b0000, "R1 idle after reset");

    run_seg(0, 20, 4, 4, -1, 0, 0, 3, 0, "R2/R3/R4/R8 voltage mode");
    run_seg(0, 24, 6, 6, -1, 0, 3, 2, 0, "R9 dead time 3");
    run_seg(1, 20, 17, 17, -1, 5, 1, 2, 0, "R5 feed-forward step 5");
    run_seg(1, 40, 65534, 65534, -1, 4095, 0, 1, 0, "R5 feed-forward saturation");
    run_seg(2, 20, 30, 30, -1, 0, 2, 2, 0, "R6 peak current ramp");
    run_seg(2, 20, 50, 50, -1, 0, 0, 2, 1, "R7 current falls and rises");
    run_seg(3, 20, 8, 8, -1, 0, 2, 2, 0, "R4/R7 trip in last clock");
    run_seg(0, 16, 0, 0, -1, 0, 0, 2, 0, "R11 zero compare");
    run_seg(0, 16, 7, 7, -1, 0, 1, 2, 0, "R11 compare at ramp max");
    run_seg(0, 20, 3, 8, 2, 0, 0, 3, 0, "R10 compare change mid period");

    summary();
    $finish;
  end
endmodule